// File: doc/BRIEF.md
# Serial-Bus Calibration Code Slave

This block is a two-wire serial bus slave (I2C protocol) that owns one 7-bit calibration code. The code is held in a volatile register whose value drives a DAC input bus directly. A second register models non-volatile storage. Writing it takes a fixed programming time, and its content is copied back into the volatile register whenever the block is reset. The bus lines are sampled by a fast system clock. SDA is driven open-drain through an output-enable, so the pin is only ever pulled low.

A master addresses the slave with a fixed 7-bit address and an R/W bit. A write carries exactly one data byte. The upper seven bits of that byte are the new code, most significant bit first. The last bit is a programming flag that asks for the code to be committed to the non-volatile register. The commit happens only when the write-protect input is low and no earlier commit is still running. A read returns the current code. Reset plays the role of power-up and reloads the code from the stored value.

Top module: `i2c_cal_slave`

## Requirements
- R1: A byte whose upper seven bits equal the device address 7'b1001111, sent right after a start condition, is acknowledged by pulling SDA low during the ninth clock. The low bit of that byte selects write (0) or read (1).
- R2: After an address byte that does not match, SDA stays released, no acknowledge is given, and the code is unchanged until the next start condition.
- R3: In a write, the first data byte is acknowledged and its bits [7:1] become the code on code_o. Any further data bytes in the same transfer are not acknowledged and do not change the code. The code changes only when a data byte is accepted.
- R4: In a read, the slave sends one byte, most significant bit first. Bits [7:1] of that byte are the current code and bit 0 is 0.
- R5: A data byte with bit 0 set, accepted while wp_i is low and no commit is running, raises busy_o for exactly PROG_CYCLES clocks. When busy_o falls, the code is held in the stored register.
- R6: Reset loads code_o from the stored register, clears busy_o, releases SDA, and abandons any commit that is running.
- R7: A data byte with bit 0 clear, or one accepted while wp_i is high, never raises busy_o and leaves the stored value unchanged.
- R8: A commit request that arrives while busy_o is high is ignored. The volatile code still takes the new value.
- R9: A repeated start restarts address matching, even after a mismatched address.
- R10: The slave changes its SDA drive only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset, acts as power-up |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| wp_i | input | 1 | High blocks commits to the stored register |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| code_o | output | 7 | Current calibration code to the DAC |
| busy_o | output | 1 | High while a commit is being programmed |

## Verification
Writes and reads are run with random codes, and each written value is read back. This separates correct bit ordering and field placement from shifted or reversed decoding. A wrong address, with and without a following repeated start, shows that matching is both strict and restartable. A surplus data byte shows that only one byte per write is accepted. Commit sequences cover four cases: protect off, protect on, flag clear, and a second request during a running commit. Each is followed by a reset. Together they tell a real commit apart from a volatile-only update, measure the busy length, and show that a reset during a commit leaves the older stored value in place.

// File: rtl/i2c_cal_pkg.sv
package i2c_cal_pkg;
  localparam int CODE_W = 7;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } bus_st_t;
endpackage

// File: rtl/i2c_cal_sync.sv
module i2c_cal_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_o[g]  = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/i2c_cal_bus.sv
module i2c_cal_bus
  import i2c_cal_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'b1001111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [CODE_W-1:0] rd_code,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_byte
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  bus_st_t            st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]  sh_q;
  logic [BYTE_W-1:0]  tx_q;
  logic               rw_q;
  logic               start_c;
  logic               stop_c;

  assign start_c = scl_lvl & sda_fall;
  assign stop_c  = scl_lvl & sda_rise;
  assign wr_byte = sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      rw_q   <= 1'b0;
      sda_oe <= 1'b0;
      wr_stb <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_c) begin
        st_q   <= ST_ADDR;
        cnt_q  <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st_q   <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_FULL) begin
              if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                rw_q   <= sh_q[0];
                sda_oe <= 1'b1;
                st_q   <= ST_AACK;
              end else begin
                st_q   <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q   <= {rd_code, 1'b0};
                sda_oe <= ~rd_code[CODE_W-1];
                st_q   <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                st_q   <= ST_WDAT;
              end
            end
          end
          ST_WDAT: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_FULL) begin
              wr_stb <= 1'b1;
              sda_oe <= 1'b1;
              st_q   <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st_q   <= ST_SKIP;
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (cnt_q == CNT_LAST) begin
                sda_oe <= 1'b0;
                st_q   <= ST_RACK;
              end else begin
                cnt_q  <= cnt_q + 1'b1;
                tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_fall) st_q <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cal_store.sv
module i2c_cal_store
  import i2c_cal_pkg::*;
#(
  parameter int                PROG_CYCLES = 4096,
  parameter logic [CODE_W-1:0] INIT_CODE   = 7'd64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              wp,
  output logic [CODE_W-1:0] code_q,
  output logic              busy_q
);
  localparam int               PC_W     = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [PC_W-1:0]  PC_LAST  = PC_W'(PROG_CYCLES - 1);

  logic [CODE_W-1:0] nv_q = INIT_CODE;
  logic [CODE_W-1:0] pend_q;
  logic [PC_W-1:0]   tmr_q;
  logic              commit_c;

  assign commit_c = wr_stb & wr_byte[0] & ~wp & ~busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= nv_q;
      busy_q <= 1'b0;
      tmr_q  <= '0;
      pend_q <= '0;
    end else begin
      if (wr_stb) code_q <= wr_byte[BYTE_W-1:1];
      if (commit_c) begin
        busy_q <= 1'b1;
        tmr_q  <= '0;
        pend_q <= wr_byte[BYTE_W-1:1];
      end else if (busy_q) begin
        if (tmr_q == PC_LAST) begin
          busy_q <= 1'b0;
          nv_q   <= pend_q;
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_cal_slave.sv
module i2c_cal_slave
  import i2c_cal_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'b1001111,
  parameter int                SYNC_STAGES = 2,
  parameter int                PROG_CYCLES = 4096,
  parameter logic [CODE_W-1:0] INIT_CODE   = 7'd64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wp_i,
  output logic              sda_oe_o,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o
);
  logic [1:0]        lvl, rise, fall;
  logic              scl_lvl;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_byte;

  i2c_cal_sync #(.STAGES(SYNC_STAGES), .LINES(2)) sync_i (
    .clk   (clk),
    .rst   (rst),
    .raw_i ({sda_i, scl_i}),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign scl_lvl = lvl[0];

  i2c_cal_bus #(.DEV_ADDR(DEV_ADDR)) bus_i (
    .clk     (clk),
    .rst     (rst),
    .scl_lvl (scl_lvl),
    .scl_rise(rise[0]),
    .scl_fall(fall[0]),
    .sda_lvl (lvl[1]),
    .sda_rise(rise[1]),
    .sda_fall(fall[1]),
    .rd_code (code_o),
    .sda_oe  (sda_oe_o),
    .wr_stb  (wr_stb),
    .wr_byte (wr_byte)
  );

  i2c_cal_store #(.PROG_CYCLES(PROG_CYCLES), .INIT_CODE(INIT_CODE)) store_i (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (wr_stb),
    .wr_byte(wr_byte),
    .wp     (wp_i),
    .code_q (code_o),
    .busy_q (busy_o)
  );
endmodule

// File: rtl/i2c_cal_chk.sv
module i2c_cal_chk
  import i2c_cal_pkg::*;
#(
  parameter int PROG_CYCLES = 4096
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              sda_oe_o,
  input logic [CODE_W-1:0] code_o,
  input logic              wp_i,
  input logic              wr_stb,
  input logic              wr_prog,
  input logic              scl_lvl
);
  int run_q;

  always_ff @(posedge clk) begin
    if (rst)         run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(busy_o)) |-> (run_q == PROG_CYCLES));

  // R5
  busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= PROG_CYCLES);

  // R7
  commit_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(busy_o)) |-> $past(wr_stb && wr_prog && !wp_i));

  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(code_o));

  // R10
  sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(sda_oe_o)) |-> !$past(scl_lvl));
endmodule

bind i2c_cal_slave i2c_cal_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .busy_o  (busy_o),
  .sda_oe_o(sda_oe_o),
  .code_o  (code_o),
  .wp_i    (wp_i),
  .wr_stb  (wr_stb),
  .wr_prog (wr_byte[0]),
  .scl_lvl (scl_lvl)
);

// File: tb/i2c_cal_slave_tb_top.sv
module i2c_cal_slave_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         QTR        = 20;
  localparam int         PROG       = 3000;
  localparam logic [6:0] DEV        = 7'b1001111;
  localparam logic [6:0] INIT       = 7'd64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       wp = 1'b0;
  logic       sda_oe;
  logic [6:0] code;
  logic       busy;
  wire        sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  int oe_hits = 0, busy_hits = 0;
  int run = 0, last_run = 0, runs = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cal_slave #(.DEV_ADDR(DEV), .SYNC_STAGES(2), .PROG_CYCLES(PROG), .INIT_CODE(INIT)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .wp_i(wp),
    .sda_oe_o(sda_oe), .code_o(code), .busy_o(busy)
  );

  always @(negedge clk) begin
    if (sda_oe) oe_hits++;
    if (busy) begin
      busy_hits++;
      run++;
    end else if (run != 0) begin
      last_run = run;
      runs++;
      run = 0;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [6:0] c);
    return {c, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (QTR) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = ~sda_line;
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit master_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq();
      b[i] = sda_line;
      wq(); scl_m = 1'b0; wq();
    end
    sda_m = ~master_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic write_txn(input logic [6:0] a, input logic [7:0] d, output bit aa, output bit ad);
    bus_start();
    send_byte({a, 1'b0}, aa);
    ad = 1'b0;
    if (aa) send_byte(d, ad);
    bus_stop();
  endtask

  task automatic read_txn(input logic [6:0] a, output bit aa, output logic [7:0] d);
    bus_start();
    send_byte({a, 1'b1}, aa);
    d = '1;
    if (aa) recv_byte(d, 1'b0);
    bus_stop();
  endtask

  task automatic do_reset();
    rst = 1'b1; repeat (4) @(negedge clk); rst = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bit aa, ad;
    logic [7:0] rb;
    logic [6:0] v;
    int r0;
    void'($urandom(32'd4711));
    do_reset();
    // R6 reset state
    chk(code == INIT, "R6 reset code", code, INIT);
    chk(busy == 1'b0, "R6 reset busy", busy, 0);
    chk(sda_oe == 1'b0, "R6 reset sda", sda_oe, 0);

    // R1 R3 basic write
    write_txn(DEV, {7'h15, 1'b0}, aa, ad);
    chk(aa, "R1 addr ack", aa, 1);
    chk(ad, "R3 data ack", ad, 1);
    chk(code == 7'h15, "R3 code", code, 7'h15);

    // R4 read back
    read_txn(DEV, aa, rb);
    chk(aa, "R1 read ack", aa, 1);
    chk(rb == exp_rd(7'h15), "R4 read byte", rb, exp_rd(7'h15));

    // R2 wrong address
    oe_hits = 0;
    write_txn(7'b1001110, {7'h7F, 1'b0}, aa, ad);
    chk(!aa, "R2 nack", aa, 0);
    chk(oe_hits == 0, "R2 sda released", oe_hits, 0);
    chk(code == 7'h15, "R2 code kept", code, 7'h15);

    // R9 repeated start after mismatch
    bus_start();
    send_byte({7'b0001111, 1'b0}, aa);
    chk(!aa, "R9 first nack", aa, 0);
    bus_start();
    send_byte({DEV, 1'b1}, aa);
    chk(aa, "R9 restart ack", aa, 1);
    recv_byte(rb, 1'b0);
    bus_stop();
    chk(rb == exp_rd(7'h15), "R9 read", rb, exp_rd(7'h15));

    // R3 surplus data byte
    bus_start();
    send_byte({DEV, 1'b0}, aa);
    send_byte({7'h22, 1'b0}, ad);
    chk(ad, "R3 first byte ack", ad, 1);
    send_byte({7'h33, 1'b0}, ad);
    chk(!ad, "R3 extra nack", ad, 0);
    bus_stop();
    chk(code == 7'h22, "R3 extra ignored", code, 7'h22);

    // R5 commit then recall
    r0 = runs;
    write_txn(DEV, {7'h5A, 1'b1}, aa, ad);
    chk(busy, "R5 busy set", busy, 1);
    wait_idle();
    chk(runs == r0 + 1 && last_run == PROG, "R5 busy length", last_run, PROG);
    write_txn(DEV, {7'h01, 1'b0}, aa, ad);
    do_reset();
    chk(code == 7'h5A, "R5 R6 recall", code, 7'h5A);

    // R7 write protect and flag clear
    wp = 1'b1; busy_hits = 0;
    write_txn(DEV, {7'h11, 1'b1}, aa, ad);
    repeat (100) @(negedge clk);
    chk(busy_hits == 0, "R7 wp no busy", busy_hits, 0);
    chk(code == 7'h11, "R7 wp volatile", code, 7'h11);
    wp = 1'b0;
    write_txn(DEV, {7'h12, 1'b0}, aa, ad);
    repeat (100) @(negedge clk);
    chk(busy_hits == 0, "R7 flag clear no busy", busy_hits, 0);
    do_reset();
    chk(code == 7'h5A, "R7 stored kept", code, 7'h5A);

    // R8 second commit while busy
    r0 = runs;
    write_txn(DEV, {7'h2B, 1'b1}, aa, ad);
    write_txn(DEV, {7'h3C, 1'b1}, aa, ad);
    chk(busy, "R8 still busy", busy, 1);
    chk(code == 7'h3C, "R8 volatile", code, 7'h3C);
    wait_idle();
    chk(runs == r0 + 1 && last_run == PROG, "R8 single run", runs - r0, 1);
    do_reset();
    chk(code == 7'h2B, "R8 first stored", code, 7'h2B);

    // R6 reset during commit
    write_txn(DEV, {7'h44, 1'b1}, aa, ad);
    chk(busy, "R6 busy before reset", busy, 1);
    do_reset();
    chk(!busy, "R6 busy cleared", busy, 0);
    chk(code == 7'h2B, "R6 commit abandoned", code, 7'h2B);
    repeat (PROG + 10) @(negedge clk);
    do_reset();
    chk(code == 7'h2B, "R6 stored after abort", code, 7'h2B);

    // R3 R4 random codes
    for (int k = 0; k < 12; k++) begin
      v = 7'($urandom % 128);
      if (k == 0) v = 7'h00;
      if (k == 1) v = 7'h7F;
      write_txn(DEV, {v, 1'b0}, aa, ad);
      chk(aa && ad, "R3 rand ack", {aa, ad}, 3);
      chk(code == v, "R3 rand code", code, v);
      read_txn(DEV, aa, rb);
      chk(rb == exp_rd(v), "R4 rand read", rb, exp_rd(v));
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule